// File: doc/BRIEF.md
# UART FIFO Interrupt and Block-Transfer Controller

This block holds the two 16-character queues of a UART, one for received characters and one for characters waiting to be sent, and turns their fill levels into the interrupt request, the two transmitter status bits and the receive and transmit ready lines. The receiver side of the UART hands characters in through a push port and the host drains them through a read port. The host writes characters for transmission through a write port and the transmit shifter takes them through a pop port.

A one-byte control register written through a simple write strobe selects the signalling scheme. In per-character mode, every character that arrives or leaves raises a request that stays high until the host services that side. In block mode, the request tracks fill levels instead: it is high while the transmit queue has any free slot or while the receive queue holds more characters than a selectable trigger level. The host can then move whole blocks per interrupt. Block mode is only honoured while the queues are enabled. Control bits: bit 0 enables the queues, bit 1 empties the receive queue, bit 2 empties the transmit queue, bit 3 selects block mode, bits 7:6 pick the receive trigger level. Bits 1 and 2 act only on the write and are not stored.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: After reset both counts are 0, `irq` is 0, `lsr_thre` is 1, `rx_ready` is 0, `tx_ready` is 1, and the control register is 0 (queues disabled, per-character mode, trigger level 1).
- R2: Each queue returns characters in the order they were accepted and holds at most 16. A push or write into a full queue is dropped and the count stays at 16.
- R3: A read or pop of an empty queue has no effect, and its count stays at 0.
- R4: A control write with bit 1 set clears the receive count on that clock edge, and bit 2 does the same for the transmit count. A clear takes priority over a push in the same cycle.
- R5: In per-character mode, an accepted receive push sets `irq` from the next cycle. It stays set until an accepted host read.
- R6: In per-character mode, an accepted transmit pop sets `irq` from the next cycle. It stays set until an accepted host write.
- R7: Block mode is active when control bits 0 and 3 are both 1. It then drives `irq` high whenever the transmit count is below 16, and any pending per-character request is discarded.
- R8: In block mode, `irq` is also high when the receive count exceeds the trigger level. Bits 7:6 give 00=1, 01=4, 10=8 and 11=14 characters.
- R9: Control bit 3 has no effect while bit 0 is 0. The block then keeps per-character signalling.
- R10: `lsr_thre` is 1 whenever the transmit count is below 16. `lsr_temt` is 1 only when the transmit count is 0 and `tx_shift_busy` is 0.
- R11: In per-character mode, `rx_ready` = receive count ≥ 1 and `tx_ready` = transmit count = 0. In block mode, `rx_ready` = receive count > trigger level and `tx_ready` = transmit count < 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| rx_push | input | 1 | Receiver delivers a character |
| rx_push_data | input | 8 | Character from the receiver |
| rx_rd | input | 1 | Host reads the oldest received character |
| rx_rd_data | output | 8 | Oldest received character |
| tx_wr | input | 1 | Host writes a character to send |
| tx_wr_data | input | 8 | Character from the host |
| tx_pop | input | 1 | Shifter takes the oldest transmit character |
| tx_pop_data | output | 8 | Oldest transmit character |
| tx_shift_busy | input | 1 | Transmit shift register still sending |
| irq | output | 1 | Interrupt request |
| lsr_thre | output | 1 | Transmit queue has a free slot |
| lsr_temt | output | 1 | Transmit queue and shifter are both empty |
| rx_ready | output | 1 | Receive ready line |
| tx_ready | output | 1 | Transmit ready line |
| rx_count | output | 5 | Receive queue occupancy |
| tx_count | output | 5 | Transmit queue occupancy |

## Verification
Counts, pending requests and the control register all update on the clock edge that samples a stimulus. `irq`, both ready lines and both status bits are derived from those registers without a further stage, so each result is due one edge after its stimulus. Data outputs show the queue head before the edge that removes it. The bench drives every input on a falling edge and holds it over one rising edge. Level checks run on the next falling edge. The scoreboard monitor compares popped data 1 ns after the driving falling edge, before the rising edge consumes it.

// File: rtl/ufic_pkg.sv
package ufic_pkg;

    typedef struct packed {
        logic       fifo_en;
        logic       blk_mode;
        logic [1:0] trig_sel;
    } ufic_cfg_t;

    // receive trigger level, scaled from the queue depth
    function automatic int trig_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/ufic_fifo.sv
module ufic_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          push_ok,
    output logic          pop_ok
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
    } fifo_state_t;

    fifo_state_t   s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        push_ok = push && !flush && (s_q.count != CW'(DEPTH));
        pop_ok  = pop  && !flush && (s_q.count != '0);
        if (flush) begin
            s_d = '0;
        end else begin
            if (push_ok) s_d.wr_ptr = ptr_inc(s_q.wr_ptr);
            if (pop_ok)  s_d.rd_ptr = ptr_inc(s_q.rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   s_d.count = s_q.count + 1'b1;
                2'b01:   s_d.count = s_q.count - 1'b1;
                default: s_d.count = s_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[s_q.wr_ptr] <= push_data;
    end

    assign head  = mem_q[s_q.rd_ptr];
    assign count = s_q.count;

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop_ok) |=> (count == $past(count) + 1'b1));

    assert_flush_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0) |=> (count == '0));

endmodule

// File: rtl/ufic_irq.sv
module ufic_irq
    import ufic_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ufic_cfg_t     cfg,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          rx_push_ok,
    input  logic          rx_rd_ok,
    input  logic          tx_pop_ok,
    input  logic          tx_wr_ok,
    input  logic          tx_shift_busy,
    output logic          irq,
    output logic          rx_ready,
    output logic          tx_ready,
    output logic          lsr_thre,
    output logic          lsr_temt
);

    typedef struct packed {
        logic rx_pend;
        logic tx_pend;
    } pend_t;

    pend_t         p_d, p_q;
    logic          blk_act;
    logic [CW-1:0] trig;
    logic          tx_room;
    logic          rx_over;

    always_comb begin
        blk_act = cfg.fifo_en && cfg.blk_mode;
        trig    = CW'(trig_level(cfg.trig_sel, DEPTH));
        tx_room = tx_count < CW'(DEPTH);
        rx_over = rx_count > trig;

        p_d = p_q;
        if (blk_act) begin
            p_d = '0;
        end else begin
            if (rx_push_ok)     p_d.rx_pend = 1'b1;
            else if (rx_rd_ok)  p_d.rx_pend = 1'b0;
            if (tx_pop_ok)      p_d.tx_pend = 1'b1;
            else if (tx_wr_ok)  p_d.tx_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_comb begin
        if (blk_act) begin
            irq      = tx_room || rx_over;
            rx_ready = rx_over;
            tx_ready = tx_room;
        end else begin
            irq      = p_q.rx_pend || p_q.tx_pend;
            rx_ready = rx_count != '0;
            tx_ready = tx_count == '0;
        end
        lsr_thre = tx_room;
        lsr_temt = (tx_count == '0) && !tx_shift_busy;
    end

    assert_chr_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_act && rx_push_ok) |=> (irq || blk_act));

    assert_chr_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_act && tx_pop_ok) |=> (irq || blk_act));

    assert_blk_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_act && tx_count < CW'(DEPTH)) |-> irq);

    assert_blk_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_act && rx_count > trig) |-> (irq && rx_ready));

    assert_temt_thre_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_temt |-> lsr_thre);

endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl
    import ufic_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_push_data,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_rd_data,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wr_data,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_pop_data,
    input  logic          tx_shift_busy,
    output logic          irq,
    output logic          lsr_thre,
    output logic          lsr_temt,
    output logic          rx_ready,
    output logic          tx_ready,
    output logic [CW-1:0] rx_count,
    output logic [CW-1:0] tx_count
);

    ufic_cfg_t cfg_d, cfg_q;
    logic      rx_flush, tx_flush;
    logic      rx_push_ok, rx_rd_ok, tx_wr_ok, tx_pop_ok;
    logic      unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_wdata[5:4];

    always_comb begin
        cfg_d    = cfg_q;
        rx_flush = cfg_we && cfg_wdata[1];
        tx_flush = cfg_we && cfg_wdata[2];
        if (cfg_we) begin
            cfg_d.fifo_en  = cfg_wdata[0];
            cfg_d.blk_mode = cfg_wdata[3];
            cfg_d.trig_sel = cfg_wdata[7:6];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    ufic_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_rd),
        .head      (rx_rd_data),
        .count     (rx_count),
        .push_ok   (rx_push_ok),
        .pop_ok    (rx_rd_ok)
    );

    ufic_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (tx_wr),
        .push_data (tx_wr_data),
        .pop       (tx_pop),
        .head      (tx_pop_data),
        .count     (tx_count),
        .push_ok   (tx_wr_ok),
        .pop_ok    (tx_pop_ok)
    );

    ufic_irq #(.DEPTH(DEPTH)) u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg           (cfg_q),
        .rx_count      (rx_count),
        .tx_count      (tx_count),
        .rx_push_ok    (rx_push_ok),
        .rx_rd_ok      (rx_rd_ok),
        .tx_pop_ok     (tx_pop_ok),
        .tx_wr_ok      (tx_wr_ok),
        .tx_shift_busy (tx_shift_busy),
        .irq           (irq),
        .rx_ready      (rx_ready),
        .tx_ready      (tx_ready),
        .lsr_thre      (lsr_thre),
        .lsr_temt      (lsr_temt)
    );

endmodule

// File: tb/uart_fifo_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_fifo_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_push_data = '0;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_rd_data;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wr_data = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_pop_data;
    logic       tx_shift_busy = 1'b0;
    logic       irq, lsr_thre, lsr_temt, rx_ready, tx_ready;
    logic [4:0] rx_count, tx_count;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_rx[$];
    logic [7:0] exp_tx[$];

    always #5 clk = ~clk;

    uart_fifo_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_rd(rx_rd),
        .rx_rd_data(rx_rd_data), .tx_wr(tx_wr), .tx_wr_data(tx_wr_data),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_shift_busy(tx_shift_busy),
        .irq(irq), .lsr_thre(lsr_thre), .lsr_temt(lsr_temt),
        .rx_ready(rx_ready), .tx_ready(tx_ready),
        .rx_count(rx_count), .tx_count(tx_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one stimulus cycle: drive on a falling edge, release on the next
    task automatic step(input logic we, input logic [7:0] wd,
                        input logic rp, input logic [7:0] rd,
                        input logic rr, input logic tw, input logic [7:0] td,
                        input logic tp);
        @(negedge clk);
        cfg_we = we; cfg_wdata = wd;
        rx_push = rp; rx_push_data = rd; rx_rd = rr;
        tx_wr = tw; tx_wr_data = td; tx_pop = tp;
        if (rp && !(we && wd[1]) && exp_rx.size() < 16) exp_rx.push_back(rd);
        if (tw && !(we && wd[2]) && exp_tx.size() < 16) exp_tx.push_back(td);
        if (we && wd[1]) exp_rx.delete();
        if (we && wd[2]) exp_tx.delete();
        @(negedge clk);
        cfg_we = 0; rx_push = 0; rx_rd = 0; tx_wr = 0; tx_pop = 0;
    endtask

    task automatic cfg(input logic [7:0] v);      step(1, v, 0, 0, 0, 0, 0, 0); endtask
    task automatic rxp(input logic [7:0] d);      step(0, 0, 1, d, 0, 0, 0, 0); endtask
    task automatic rxr();                         step(0, 0, 0, 0, 1, 0, 0, 0); endtask
    task automatic txw(input logic [7:0] d);      step(0, 0, 0, 0, 0, 1, d, 0); endtask
    task automatic txp();                         step(0, 0, 0, 0, 0, 0, 0, 1); endtask

    // scoreboard monitor: compares queue heads before the consuming edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rx_rd && exp_rx.size() > 0) begin
                chk("R2 rx order", rx_rd_data, exp_rx[0]);
                void'(exp_rx.pop_front());
            end
            if (tx_pop && exp_tx.size() > 0) begin
                chk("R2 tx order", tx_pop_data, exp_tx[0]);
                void'(exp_tx.pop_front());
            end
        end
    end

    logic done = 1'b0;
    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_count", tx_count, 0);
        chk("R1 irq", irq, 0);
        chk("R1 thre", lsr_thre, 1);
        chk("R1 temt", lsr_temt, 1);
        chk("R11 rx_ready idle", rx_ready, 0);
        chk("R11 tx_ready idle", tx_ready, 1);

        // per-character receive
        cfg(8'h01);
        rxp(8'hA5);
        chk("R5 irq after push", irq, 1);
        chk("R11 rx_ready mode0", rx_ready, 1);
        rxp(8'h3C);
        chk("R5 irq held", irq, 1);
        rxr();
        chk("R5 irq cleared by read", irq, 0);
        rxr();
        chk("R2 rx count drained", rx_count, 0);
        rxr();
        chk("R3 rx empty read", rx_count, 0);

        // fill transmit queue, overflow, per-character transmit
        for (int i = 0; i < 16; i++) txw(8'(i * 7 + 1));
        chk("R2 tx full", tx_count, 16);
        chk("R10 thre full", lsr_thre, 0);
        chk("R10 temt full", lsr_temt, 0);
        txw(8'hEE);
        chk("R2 tx drop when full", tx_count, 16);
        txp();
        chk("R6 irq after pop", irq, 1);
        chk("R10 thre with room", lsr_thre, 1);
        txw(8'h77);
        chk("R6 irq cleared by write", irq, 0);
        for (int i = 0; i < 16; i++) txp();
        chk("R2 tx drained", tx_count, 0);
        txp();
        chk("R3 tx empty pop", tx_count, 0);
        tx_shift_busy = 1'b1;
        @(negedge clk);
        chk("R10 temt shifter busy", lsr_temt, 0);
        tx_shift_busy = 1'b0;
        @(negedge clk);
        chk("R10 temt idle", lsr_temt, 1);

        // block bit ignored while queues disabled
        txw(8'h11);
        chk("R6 irq cleared", irq, 0);
        cfg(8'h08);
        chk("R9 no block irq", irq, 0);
        chk("R9 tx_ready mode0", tx_ready, 0);
        txp();
        chk("R9 per-char still", irq, 1);

        // block mode, trigger 4
        cfg(8'h49);
        chk("R7 irq tx room", irq, 1);
        chk("R11 tx_ready block", tx_ready, 1);
        for (int i = 0; i < 16; i++) txw(8'(8'h80 + i));
        chk("R7 irq tx full", irq, 0);
        chk("R11 tx_ready full", tx_ready, 0);
        for (int i = 0; i < 4; i++) rxp(8'(8'h40 + i));
        chk("R8 irq at trigger", irq, 0);
        chk("R11 rx_ready at trigger", rx_ready, 0);
        rxp(8'h44);
        chk("R8 irq above trigger", irq, 1);
        chk("R11 rx_ready above", rx_ready, 1);
        rxr();
        chk("R8 irq back at trigger", irq, 0);

        // clears
        cfg(8'h4B);
        chk("R4 rx cleared", rx_count, 0);
        chk("R4 tx kept", tx_count, 16);
        step(1, 8'h4F, 1, 8'h99, 0, 1, 8'h98, 0);
        chk("R4 rx clear beats push", rx_count, 0);
        chk("R4 tx clear beats write", tx_count, 0);
        chk("R7 irq after clear", irq, 1);

        // block mode, trigger 14
        cfg(8'hC9);
        for (int i = 0; i < 16; i++) txw(8'(i));
        for (int i = 0; i < 14; i++) rxp(8'(8'h20 + i));
        chk("R8 irq at 14", irq, 0);
        rxp(8'h2E);
        chk("R8 irq above 14", irq, 1);
        for (int i = 0; i < 15; i++) rxr();
        chk("R2 rx drained", rx_count, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule